// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the station side of a two-wire management bus. It takes one command at a time on a valid/ready handshake. A command is a read or a write, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block turns each command into a complete management frame on MDC and MDIO, and then returns the outcome with a one-cycle response pulse.

MDC is derived from the system clock. Its half period is a programmable number of system clocks, and a parameter sets a floor on that number. MDC toggles only while a frame is in flight and rests low otherwise. MDIO is split into an output value, an output enable and an input, and a pull-up is assumed outside the block. The block changes its MDIO outputs only on falling MDC edges and samples MDIO on rising edges.

The controller is one state machine with six states:
- `ST_QUIET`: the bus is held silent after reset for at least one MDC period.
- `ST_IDLE`: a command is accepted here.
- `ST_PRE`: the preamble is sent.
- `ST_HDR`: start, opcode and the two addresses are sent.
- `ST_TURN`: the turnaround bits.
- `ST_DATA`: the payload bits.

The transitions are:
- quiet-done: `ST_QUIET` to `ST_IDLE`.
- accept: `ST_IDLE` to `ST_PRE`.
- preamble-end: `ST_PRE` to `ST_HDR`, on the fall that closes bit 31.
- header-end: `ST_HDR` to `ST_TURN`, on the fall that closes bit 45.
- turn-end: `ST_TURN` to `ST_DATA`, on the fall that closes bit 47.
- frame-end: `ST_DATA` to `ST_IDLE`, on the fall that closes bit 63.

Top module: `mdio_master`

## Requirements
- R1: During reset MDC is low, the MDIO enable is low, `cmd_ready` is low and `rsp_valid` is low. After reset is released, `cmd_ready` stays low for at least 2×H system clocks. H is the effective half period defined in R2.
- R2: Each MDC high phase lasts exactly H system clocks, where H = max(`cfg_half`, MIN_HALF) and MIN_HALF defaults to 2. This keeps MDC at or below 25 MHz from a 100 MHz clock.
- R3: While no frame is in progress (`cmd_ready` high), MDC is low and the MDIO enable is low.
- R4: A frame is 64 MDC periods long. The first 32 bits are ones, driven with the enable high.
- R5: Bits 32–45 are driven, in this order: start bits 0 then 1; the opcode (read = 1,0; write = 0,1); the PHY address, MSB first; the register address, MSB first.
- R6: In a write, bits 46–47 are driven as 1 then 0, and bits 48–63 carry `cmd_wdata` MSB first. The enable is high for all 64 bits.
- R7: In a read, the enable is low for bits 46–63, so the line is released through both turnaround bits and the data.
- R8: In a read, each data bit is sampled on the rising MDC edge. The 16 bits are returned in `rsp_data` in arrival order, with the first bit as the MSB, and `rsp_err` is 0.
- R9: `mdio_o` and `mdio_oe` change only in the cycle MDC falls, or when a command is accepted.
- R10: In a read, if the line is high at the rising edge of bit 47 (the second turnaround bit), `rsp_err` is 1 and `rsp_data` is 0.
- R11: `rsp_valid` is a single-cycle pulse. It appears 128×H clocks after the accepting edge, in the same cycle that MDC returns low and `cmd_ready` returns high. For writes, `rsp_err` and `rsp_data` are 0.
- R12: `cmd_ready` stays low from acceptance until the response. Command inputs presented while busy have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | DIV_W | Requested MDC half period, in system clocks |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle; command taken when valid and ready are both high |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Write payload |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Read turnaround fault |
| rsp_data | output | 16 | Read data, or 0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO line as seen at the pin |

## Verification
A wrong bit counter or a wrong state shows up at MDIO as a preamble, header or payload bit in the wrong slot. It also shows up at MDIO as the enable being high while the PHY should own the line. The bench observes both on the first MDC rising edge that carries the bad bit. A faulty divider changes the width of the very next MDC high phase, and it also moves the response pulse away from 128×H clocks after acceptance. A state machine that leaves idle early, or stays busy too long, shows as `cmd_ready` rising before `rsp_valid` or as a latency mismatch at the end of the same frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_LEN    = 32;
    localparam int HDR_LEN    = 4 + 2 * ADDR_W;
    localparam int TA_LEN     = 2;
    localparam int BODY_LEN   = HDR_LEN + TA_LEN + DATA_W;
    localparam int FRAME_BITS = PRE_LEN + BODY_LEN;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] TA_WRITE   = 2'b10;

    typedef enum logic [2:0] {
        ST_QUIET,
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } mdio_state_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_i,
    output logic [DIV_W-1:0] eff_half_o,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             terminal;

    always_comb begin
        eff_half_o = (half_i < MIN_H) ? MIN_H : half_i;
        terminal   = (cnt_q == eff_half_o - 1'b1);
        rise_o     = run && terminal && !mdc_q;
        fall_o     = run && terminal && mdc_q;
        mdc_o      = mdc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (terminal) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: an edge never follows the previous edge on the next clock when MIN_HALF >= 2
    p_no_back_to_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (MIN_HALF >= 2 && run && $rose(mdc_q)) |=> !$fell(mdc_q));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [DIV_W-1:0]  eff_half,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              run_o,
    output logic [DIV_W-1:0]  half_o,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data
);

    localparam logic [CNT_W-1:0] LAST_PRE  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_HDR  = CNT_W'(PRE_LEN + HDR_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_TA   = CNT_W'(PRE_LEN + HDR_LEN + TA_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FIRST_BODY = CNT_W'(PRE_LEN);

    mdio_state_e          state, nxt;
    logic [CNT_W-1:0]     bitcnt;
    logic [BODY_LEN-1:0]  frame;
    logic                 is_read;
    logic                 ta_bad;
    logic [DATA_W-1:0]    rd_sr;
    logic [DIV_W-1:0]     half_q;
    logic [DIV_W:0]       qcnt;
    logic [DIV_W:0]       quiet_lim;

    logic                 accept;
    logic                 busy;
    logic [CNT_W-1:0]     bitcnt_nxt;
    logic [BODY_LEN-1:0]  frame_nxt;
    logic                 drive_nxt;

    always_comb begin
        busy       = (state == ST_PRE) || (state == ST_HDR) ||
                     (state == ST_TURN) || (state == ST_DATA);
        cmd_ready  = (state == ST_IDLE);
        accept     = cmd_valid && cmd_ready;
        run_o      = busy;
        half_o     = half_q;
        quiet_lim  = {eff_half, 1'b0} - 1'b1;
        bitcnt_nxt = bitcnt + 1'b1;
        frame_nxt  = (bitcnt >= FIRST_BODY) ? (frame << 1) : frame;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_QUIET: if (qcnt >= quiet_lim)             nxt = ST_IDLE;
            ST_IDLE:  if (accept)                        nxt = ST_PRE;
            ST_PRE:   if (fall_i && bitcnt == LAST_PRE)  nxt = ST_HDR;
            ST_HDR:   if (fall_i && bitcnt == LAST_HDR)  nxt = ST_TURN;
            ST_TURN:  if (fall_i && bitcnt == LAST_TA)   nxt = ST_DATA;
            ST_DATA:  if (fall_i && bitcnt == LAST_BIT)  nxt = ST_IDLE;
            default:                                     nxt = ST_IDLE;
        endcase
        drive_nxt = (nxt == ST_PRE) || (nxt == ST_HDR) || !is_read;
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_QUIET;
            bitcnt  <= '0;
            frame   <= '0;
            is_read <= 1'b0;
            ta_bad  <= 1'b0;
            rd_sr   <= '0;
            half_q  <= '0;
            qcnt    <= '0;
        end else begin
            state <= nxt;
            if (state == ST_QUIET || state == ST_IDLE) begin
                half_q <= cfg_half;
            end
            if (state == ST_QUIET) begin
                qcnt <= qcnt + 1'b1;
            end
            if (accept) begin
                bitcnt  <= '0;
                is_read <= cmd_read;
                ta_bad  <= 1'b0;
                rd_sr   <= '0;
                frame   <= {START_CODE, (cmd_read ? OP_READ : OP_WRITE), cmd_phy, cmd_reg,
                            (cmd_read ? 2'b11 : TA_WRITE),
                            (cmd_read ? {DATA_W{1'b1}} : cmd_wdata)};
            end else if (busy && fall_i) begin
                bitcnt <= bitcnt_nxt;
                frame  <= frame_nxt;
            end
            if (busy && rise_i && is_read) begin
                if (state == ST_TURN && bitcnt == LAST_TA) begin
                    ta_bad <= mdio_i;
                end
                if (state == ST_DATA) begin
                    rd_sr <= {rd_sr[DATA_W-2:0], mdio_i};
                end
            end
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o    <= 1'b1;
            mdio_oe   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (busy && fall_i) begin
                if (nxt == ST_IDLE) begin
                    mdio_o    <= 1'b1;
                    mdio_oe   <= 1'b0;
                    rsp_valid <= 1'b1;
                    rsp_err   <= is_read && ta_bad;
                    rsp_data  <= (is_read && !ta_bad) ? rd_sr : '0;
                end else begin
                    mdio_o  <= (bitcnt_nxt < FIRST_BODY) ? 1'b1 : frame_nxt[BODY_LEN-1];
                    mdio_oe <= drive_nxt;
                end
            end
        end
    end

    p_release_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_TURN || state == ST_DATA) && is_read) |-> !mdio_oe);

    p_out_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !fall_i) |=> ($stable(mdio_o) && $stable(mdio_oe)));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_err_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_data == '0));

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int MIN_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic             run;
    logic             rise;
    logic             fall;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] eff_half;

    mdio_clkgen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .half_i     (half),
        .eff_half_o (eff_half),
        .mdc_o      (mdc),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    mdio_frame_fsm #(.DIV_W(DIV_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_half  (cfg_half),
        .eff_half  (eff_half),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_read  (cmd_read),
        .cmd_phy   (cmd_phy),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .rise_i    (rise),
        .fall_i    (fall),
        .run_o     (run),
        .half_o    (half),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data)
    );

    // R3: the bus is parked whenever a command could be taken
    p_idle_bus_parked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mdc && !mdio_oe));

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;
    localparam int MIN_HALF   = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [DIV_W-1:0] cfg_half;
    logic             cmd_valid;
    logic             cmd_ready;
    logic             cmd_read;
    logic [4:0]       cmd_phy;
    logic [4:0]       cmd_reg;
    logic [15:0]      cmd_wdata;
    logic             rsp_valid;
    logic             rsp_err;
    logic [15:0]      rsp_data;
    logic             mdc;
    logic             mdio_o;
    logic             mdio_oe;
    logic             mdio_i;

    logic             phy_drv = 1'b0;
    logic             phy_bit = 1'b1;
    logic             phy_ta  = 1'b0;
    logic [15:0]      phy_data = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [63:0] cap_bits;
    logic [63:0] cap_oe;
    int          nbits = 0;
    int          hlen = 0;
    int          bad_hi = 0;
    int          cur_eff = 2;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

    mdio_master #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] wd,
                                              input bit ta, input logic [15:0] rdd);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? {1'b1, ta} : 2'b10), (rd ? rdd : wd)};
    endfunction

    function automatic logic [63:0] exp_oe(input bit rd);
        return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    endfunction

    // bus monitor: what the PHY sees at each rising MDC edge
    always @(posedge mdc) begin
        if (nbits < 64) begin
            cap_bits[63 - nbits] = mdio_i;
            cap_oe[63 - nbits]   = mdio_oe;
        end
        nbits = nbits + 1;
    end

    // PHY model: drives on falling MDC during a read
    always @(negedge mdc) begin
        phy_drv = 1'b0;
        phy_bit = 1'b1;
        if (nbits >= 36 && nbits < 64 && cap_bits[63-34] && !cap_bits[63-35]) begin
            if (nbits == 47) begin
                phy_drv = 1'b1;
                phy_bit = phy_ta;
            end else if (nbits >= 48) begin
                phy_drv = 1'b1;
                phy_bit = phy_data[63 - nbits];
            end
        end
    end

    // MDC high-phase width monitor
    always @(negedge clk) begin
        if (mdc) begin
            hlen = hlen + 1;
        end else if (hlen != 0) begin
            if (hlen != cur_eff) bad_hi = bad_hi + 1;
            hlen = 0;
        end
    end

    task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input int half, input bit ta,
                           input logic [15:0] rdd);
        int k;
        bit early;
        logic [63:0] ef;
        logic [63:0] eo;
        @(negedge clk);
        cfg_half = DIV_W'(half);
        cur_eff  = (half < MIN_HALF) ? MIN_HALF : half;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_read  = rd;
        cmd_phy   = phy;
        cmd_reg   = rg;
        cmd_wdata = wd;
        phy_ta    = ta;
        phy_data  = rdd;
        nbits     = 0;
        bad_hi    = 0;
        cmd_valid = 1'b1;
        @(negedge clk);
        // R12: keep offering a different command while busy
        cmd_read  = ~rd;
        cmd_phy   = ~phy;
        cmd_reg   = ~rg;
        cmd_wdata = ~wd;
        k = 0;
        early = 0;
        while (!rsp_valid && k < 20000) begin
            if (cmd_ready) early = 1;
            if (k == 20) cmd_valid = 1'b0;
            @(negedge clk);
            k++;
        end
        cmd_valid = 1'b0;
        ef = exp_frame(rd, phy, rg, wd, ta, rdd);
        eo = exp_oe(rd);
        check(k == 128 * cur_eff, "R11", "response latency", 64'(k), 64'(128 * cur_eff));
        check(cmd_ready && !mdc && !mdio_oe, "R3", "bus parked at end",
              {61'b0, cmd_ready, mdc, mdio_oe}, 64'b100);
        check(!early, "R12", "ready low while busy", 64'(early), 64'd0);
        check(nbits == 64, "R4", "frame length", 64'(nbits), 64'd64);
        check(cap_bits[63:32] == ef[63:32] && cap_oe[63:32] == 32'hFFFF_FFFF, "R4",
              "preamble", {cap_bits[63:32], cap_oe[63:32]}, {ef[63:32], 32'hFFFF_FFFF});
        check(cap_bits[31:18] == ef[31:18], "R5", "header bits",
              64'(cap_bits[31:18]), 64'(ef[31:18]));
        check(bad_hi == 0, "R2", "MDC high phase width", 64'(bad_hi), 64'd0);
        if (rd) begin
            check(cap_oe == eo, "R7", "read enable pattern", cap_oe, eo);
            if (ta) begin
                check(rsp_err && rsp_data == 16'h0, "R10", "turnaround fault",
                      {47'b0, rsp_err, rsp_data}, {47'b0, 1'b1, 16'h0});
            end else begin
                check(!rsp_err && rsp_data == rdd, "R8", "read data",
                      {47'b0, rsp_err, rsp_data}, {47'b0, 1'b0, rdd});
            end
        end else begin
            check(cap_bits[17:0] == ef[17:0] && cap_oe == eo, "R6", "write payload",
                  {cap_bits[17:0], cap_oe[45:0]}, {ef[17:0], eo[45:0]});
            check(!rsp_err && rsp_data == 16'h0, "R11", "write response",
                  {47'b0, rsp_err, rsp_data}, 64'd0);
        end
        @(negedge clk);
        check(!rsp_valid, "R11", "pulse width", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int q;
        bit mdc_seen;
        void'($urandom(32'd2024));
        rst_n     = 1'b0;
        cfg_half  = 8'd3;
        cmd_valid = 1'b0;
        cmd_read  = 1'b0;
        cmd_phy   = '0;
        cmd_reg   = '0;
        cmd_wdata = '0;
        repeat (4) @(negedge clk);
        check(!mdc && !mdio_oe && !cmd_ready && !rsp_valid, "R1", "reset outputs",
              {60'b0, mdc, mdio_oe, cmd_ready, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        q = 0;
        mdc_seen = 0;
        while (!cmd_ready && q < 1000) begin
            @(negedge clk);
            if (mdc) mdc_seen = 1;
            q++;
        end
        check(q >= 6 && !mdc_seen, "R1", "quiet period after reset", 64'(q), 64'd6);

        // directed corners
        run_cmd(0, 5'h01, 5'h00, 16'hA5C3, 0, 0, 16'h0);  // R2 clamp of a too-small divider
        run_cmd(1, 5'h1F, 5'h1F, 16'h0,    2, 0, 16'hFFFF);
        run_cmd(1, 5'h00, 5'h00, 16'h0,    1, 0, 16'h0000);
        run_cmd(1, 5'h0A, 5'h15, 16'h0,    3, 1, 16'h1234); // R10 fault injection
        run_cmd(0, 5'h1F, 5'h1F, 16'h0000, 2, 0, 16'h0);
        run_cmd(0, 5'h00, 5'h00, 16'hFFFF, 4, 0, 16'h0);

        // constrained random
        for (int i = 0; i < 16; i++) begin
            bit rd = 1'($urandom());
            logic [4:0] p = 5'($urandom());
            logic [4:0] r = 5'($urandom());
            logic [15:0] w = 16'($urandom());
            logic [15:0] d = 16'($urandom());
            int h = int'($urandom() % 6);
            bit t = (($urandom() % 8) == 0);
            run_cmd(rd, p, r, w, h, rd && t, d);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule